// File: doc/BRIEF.md
# Multiframe Timing Marker Extractor

This block takes the multiframe-phase and timing-marker field from the maintenance byte of each received frame. An upstream framer finds that byte and presents it with a one-cycle strobe. The block then debounces the field into a stored status value. There are two storage modes. In integrated mode the three low bits of the byte are debounced directly. In extracted mode a four-bit timing source word is rebuilt serially over a four-frame multiframe, and each complete word is debounced.

Word reassembly is a four-state machine: `ASM_HUNT` (waiting for phase 00), `ASM_HAVE0`, `ASM_HAVE1` and `ASM_HAVE2` (phases 00, 01 and 10 seen in order). The transitions are as follows:
- Advance: the expected phase arrives. Each state moves to the next one. From `ASM_HAVE2`, the expected phase 11 completes the word and the machine returns to `ASM_HUNT`.
- Restart: phase 00 arrives out of sequence. The machine goes to `ASM_HAVE0` and starts a new word with that bit.
- Abandon: any other phase arrives out of sequence. The machine goes to `ASM_HUNT`.
- Flush: the storage mode changes. The machine goes to `ASM_HUNT`.

A shared debouncer holds a candidate value, a run count and a count of quiet samples. It drives the stored value, a sticky change flag and a sticky unstable flag.

Top module: `tsi_marker_extract`

## Requirements
- R1: Bit 7 of `ma_byte` is the first bit of the byte. The phase is `ma_byte[2:1]`, the timing marker bit is `ma_byte[0]`, and the integrated field is `ma_byte[2:0]`. Bits 7..3 have no effect.
- R2: In integrated mode (`mode_ext`=0), a 3-bit field is written to `stored_val[2:0]` on the 5th consecutive strobe carrying that same field. `stored_val[3]` stays 0.
- R3: In extracted mode (`mode_ext`=1), four consecutive strobes with phases 00, 01, 10 and 11 form one word. The marker bit at phase 00 becomes bit 3 (MSB), phase 01 gives bit 2, phase 10 gives bit 1 and phase 11 gives bit 0.
- R4: A phase out of sequence discards the partial word. If that phase is 00, a new word starts with it. Any other phase makes the block ignore strobes until the next 00.
- R5: In extracted mode, a word is written to `stored_val` when the 5th consecutive identical complete word arrives. Incomplete multiframes produce no sample.
- R6: `chg_flag` rises in the cycle after a new value is written that differs from the old stored value. It stays high until `clr_status`. A new write in the same cycle as `clr_status` takes priority.
- R7: In extracted mode, `unstable_flag` rises when 8 consecutive samples (complete words) all have a run count below 5. It stays high until `clr_status`. It never rises in integrated mode.
- R8: `clr_status` clears both flags and leaves `stored_val` unchanged.
- R9: When `mode_ext` differs from its value in the previous cycle, all state is cleared. This includes the stored value, both flags, the candidate value and any partial word. A strobe in that cycle is ignored.
- R10: After reset, `stored_val` is 0, both flags are 0 and the assembler is in `ASM_HUNT`.
- R11: While `ma_valid` is low, `ma_byte` has no effect. A run in progress is not broken by cycles without a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ma_valid | input | 1 | One-cycle strobe marking a valid maintenance byte |
| ma_byte | input | 8 | Maintenance byte of the current frame |
| mode_ext | input | 1 | 0 = integrated 3-bit field, 1 = extracted 4-bit word |
| clr_status | input | 1 | Clears the change and unstable flags |
| stored_val | output | 4 | Debounced value |
| chg_flag | output | 1 | Sticky flag: stored value changed |
| unstable_flag | output | 1 | Sticky flag: no steady value over 8 samples (extracted mode) |

## Verification
The bench targets these corner cases:
- A phase-00 restart in the middle of a word. A design that simply hunts would lose the restarted word and never accept it.
- A bad phase followed by a stray 10 and 11. A design that keeps the partial word would emit a false word and break the run.
- A strobe in the same cycle as a mode change. If that strobe is not dropped, it completes an extra word early and the value is accepted one multiframe too soon.
- A clear in the same cycle as a new write. If the clear wins, the change is lost.
- A clear in the same cycle as a strobe. The unstable threshold is probed one sample before and at 8 samples. Strobe-less cycles with junk bytes are placed inside runs to catch a design that ignores `ma_valid`.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
    localparam int TSI_W   = 4;
    localparam int FIELD_W = 3;
    localparam int PHASE_W = 2;

    typedef enum logic [1:0] {
        ASM_HUNT  = 2'd0,
        ASM_HAVE0 = 2'd1,
        ASM_HAVE1 = 2'd2,
        ASM_HAVE2 = 2'd3
    } asm_state_t;
endpackage

// File: rtl/tsi_assembler.sv
module tsi_assembler
    import tsi_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic               strobe,
    input  logic [PHASE_W-1:0] phase,
    input  logic               mark,
    output logic               word_valid,
    output logic [TSI_W-1:0]   word
);
    asm_state_t         state_q, state_d;
    logic [PHASE_W-1:0] exp_phase;
    logic               take;
    logic [TSI_W-1:1]   bits_q;

    // expected phase for the current state
    always_comb begin
        exp_phase = 2'b00;
        unique case (state_q)
            ASM_HUNT:  exp_phase = 2'b00;
            ASM_HAVE0: exp_phase = 2'b01;
            ASM_HAVE1: exp_phase = 2'b10;
            ASM_HAVE2: exp_phase = 2'b11;
        endcase
    end

    // next state
    always_comb begin
        state_d = state_q;
        take    = 1'b0;
        if (flush) begin
            state_d = ASM_HUNT;
        end else if (strobe) begin
            if (phase == exp_phase) begin
                take = 1'b1;
                unique case (state_q)
                    ASM_HUNT:  state_d = ASM_HAVE0;
                    ASM_HAVE0: state_d = ASM_HAVE1;
                    ASM_HAVE1: state_d = ASM_HAVE2;
                    ASM_HAVE2: state_d = ASM_HUNT;
                endcase
            end else if (phase == 2'b00) begin
                take    = 1'b1;
                state_d = ASM_HAVE0;
            end else begin
                state_d = ASM_HUNT;
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ASM_HUNT;
        else        state_q <= state_d;
    end

    // serial bits: phase p holds bit (3 - p), MSB first
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bits_q <= '0;
        end else if (take && phase != 2'b11) begin
            bits_q[2'd3 - phase] <= mark;
        end
    end

    // outputs
    always_comb begin
        word_valid = strobe && !flush && (state_q == ASM_HAVE2) && (phase == 2'b11);
        word       = {bits_q, mark};
    end

    AST_BAD_PHASE_HUNTS: assert property (@(posedge clk) disable iff (!rst_n)
        strobe && !flush && phase != exp_phase && phase != 2'b00 |=> state_q == ASM_HUNT); // R4
    AST_ZERO_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        strobe && !flush && phase == 2'b00 |=> state_q == ASM_HAVE0); // R4
endmodule

// File: rtl/tsi_integrator.sv
module tsi_integrator #(
    parameter int W          = 4,
    parameter int ACCEPT_N   = 5,
    parameter int UNSTABLE_N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         clear,
    input  logic         unst_en,
    input  logic         smp_valid,
    input  logic [W-1:0] smp,
    output logic [W-1:0] value,
    output logic         chg,
    output logic         unst
);
    localparam int RUN_W   = $clog2(ACCEPT_N + 1);
    localparam int QUIET_W = $clog2(UNSTABLE_N + 1);
    localparam logic [RUN_W-1:0]   RUN_MAX   = RUN_W'(ACCEPT_N);
    localparam logic [QUIET_W-1:0] QUIET_MAX = QUIET_W'(UNSTABLE_N);

    logic [W-1:0]       cand_q, value_q;
    logic [RUN_W-1:0]   run_q, run_nx;
    logic [QUIET_W-1:0] quiet_q, quiet_nx;
    logic               chg_q, unst_q;
    logic               steady, accept;

    always_comb begin
        if (smp != cand_q)        run_nx = RUN_W'(1);
        else if (run_q == RUN_MAX) run_nx = run_q;
        else                       run_nx = run_q + RUN_W'(1);
        steady = (run_nx == RUN_MAX);
        accept = steady && (smp != value_q);
        if (steady)                  quiet_nx = '0;
        else if (quiet_q == QUIET_MAX) quiet_nx = quiet_q;
        else                           quiet_nx = quiet_q + QUIET_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cand_q  <= '0;
            value_q <= '0;
            run_q   <= '0;
            quiet_q <= '0;
        end else if (flush) begin
            cand_q  <= '0;
            value_q <= '0;
            run_q   <= '0;
            quiet_q <= '0;
        end else if (smp_valid) begin
            cand_q  <= smp;
            run_q   <= run_nx;
            quiet_q <= quiet_nx;
            if (accept) value_q <= smp;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chg_q  <= 1'b0;
            unst_q <= 1'b0;
        end else if (flush) begin
            chg_q  <= 1'b0;
            unst_q <= 1'b0;
        end else begin
            if (smp_valid && accept)                         chg_q <= 1'b1;
            else if (clear)                                  chg_q <= 1'b0;
            if (smp_valid && unst_en && quiet_nx == QUIET_MAX) unst_q <= 1'b1;
            else if (clear)                                  unst_q <= 1'b0;
        end
    end

    assign value = value_q;
    assign chg   = chg_q;
    assign unst  = unst_q;

    AST_ACCEPT_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (value_q != $past(value_q)) && !$past(flush)
        |-> $past(smp_valid) && $past(smp) == value_q && $past(run_q) == RUN_MAX - RUN_W'(1)); // R5
    AST_UNST_NEEDS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unst_q) |-> quiet_q == QUIET_MAX); // R7
    AST_CLEAR_KEEPS_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        clear && !smp_valid && !flush |=> $stable(value_q)); // R8
endmodule

// File: rtl/tsi_marker_extract.sv
module tsi_marker_extract
    import tsi_pkg::*;
#(
    parameter int ACCEPT_N   = 5,
    parameter int UNSTABLE_N = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ma_valid,
    input  logic [7:0]       ma_byte,
    input  logic             mode_ext,
    input  logic             clr_status,
    output logic [TSI_W-1:0] stored_val,
    output logic             chg_flag,
    output logic             unstable_flag
);
    logic             mode_q, mode_sw;
    logic             live_strobe;
    logic             word_valid;
    logic [TSI_W-1:0] word;
    logic             smp_valid;
    logic [TSI_W-1:0] smp;
    logic             unused_hi;

    assign unused_hi = ^ma_byte[7:3];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= 1'b0;
        else        mode_q <= mode_ext;
    end

    always_comb begin
        mode_sw     = (mode_ext != mode_q);
        live_strobe = ma_valid && !mode_sw;
        smp_valid   = mode_ext ? word_valid : live_strobe;
        smp         = mode_ext ? word : {1'b0, ma_byte[FIELD_W-1:0]};
    end

    tsi_assembler u_asm (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (mode_sw),
        .strobe     (live_strobe && mode_ext),
        .phase      (ma_byte[2:1]),
        .mark       (ma_byte[0]),
        .word_valid (word_valid),
        .word       (word)
    );

    tsi_integrator #(
        .W          (TSI_W),
        .ACCEPT_N   (ACCEPT_N),
        .UNSTABLE_N (UNSTABLE_N)
    ) u_int (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (mode_sw),
        .clear     (clr_status),
        .unst_en   (mode_ext),
        .smp_valid (smp_valid),
        .smp       (smp),
        .value     (stored_val),
        .chg       (chg_flag),
        .unst      (unstable_flag)
    );

    AST_MODE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mode_sw) |-> stored_val == '0 && !chg_flag && !unstable_flag); // R9
    AST_INT_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_q |-> !stored_val[TSI_W-1]); // R2
    AST_INT_NO_UNSTABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_q |-> !unstable_flag); // R7
    AST_CHG_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (stored_val != $past(stored_val)) && !$past(mode_sw) |-> chg_flag); // R6
endmodule

// File: tb/tsi_marker_extract_bench.sv
module tsi_marker_extract_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ma_valid = 1'b0;
    logic [7:0] ma_byte = 8'h00;
    logic       mode_ext = 1'b0;
    logic       clr_status = 1'b0;
    logic [3:0] stored_val;
    logic       chg_flag;
    logic       unstable_flag;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    tsi_marker_extract u_tsi_marker_extract (
        .clk           (clk),
        .rst_n         (rst_n),
        .ma_valid      (ma_valid),
        .ma_byte       (ma_byte),
        .mode_ext      (mode_ext),
        .clr_status    (clr_status),
        .stored_val    (stored_val),
        .chg_flag      (chg_flag),
        .unstable_flag (unstable_flag)
    );

    // {valid, byte, clr, exp_val, exp_chg, exp_unst}; integrated mode
    localparam logic [15:0] VEC [27] = '{
        {1'b1, 8'h05, 1'b0, 4'h0, 1'b0, 1'b0},
        {1'b1, 8'h05, 1'b0, 4'h0, 1'b0, 1'b0},
        {1'b1, 8'h05, 1'b0, 4'h0, 1'b0, 1'b0},
        {1'b1, 8'h05, 1'b0, 4'h0, 1'b0, 1'b0},
        {1'b1, 8'h05, 1'b0, 4'h5, 1'b1, 1'b0},
        {1'b0, 8'h07, 1'b1, 4'h5, 1'b0, 1'b0},
        {1'b1, 8'hFA, 1'b0, 4'h5, 1'b0, 1'b0},
        {1'b1, 8'hF2, 1'b0, 4'h5, 1'b0, 1'b0},
        {1'b1, 8'h0A, 1'b0, 4'h5, 1'b0, 1'b0},
        {1'b1, 8'h03, 1'b0, 4'h5, 1'b0, 1'b0},
        {1'b1, 8'h63, 1'b0, 4'h5, 1'b0, 1'b0},
        {1'b0, 8'h04, 1'b0, 4'h5, 1'b0, 1'b0},
        {1'b1, 8'h03, 1'b0, 4'h5, 1'b0, 1'b0},
        {1'b1, 8'h03, 1'b0, 4'h5, 1'b0, 1'b0},
        {1'b1, 8'h9B, 1'b0, 4'h3, 1'b1, 1'b0},
        {1'b0, 8'h07, 1'b1, 4'h3, 1'b0, 1'b0},
        {1'b1, 8'h03, 1'b0, 4'h3, 1'b0, 1'b0},
        {1'b1, 8'h01, 1'b0, 4'h3, 1'b0, 1'b0},
        {1'b1, 8'h02, 1'b0, 4'h3, 1'b0, 1'b0},
        {1'b1, 8'h01, 1'b0, 4'h3, 1'b0, 1'b0},
        {1'b1, 8'h02, 1'b0, 4'h3, 1'b0, 1'b0},
        {1'b1, 8'h01, 1'b0, 4'h3, 1'b0, 1'b0},
        {1'b1, 8'h02, 1'b0, 4'h3, 1'b0, 1'b0},
        {1'b1, 8'h01, 1'b0, 4'h3, 1'b0, 1'b0},
        {1'b1, 8'h02, 1'b0, 4'h3, 1'b0, 1'b0},
        {1'b1, 8'h01, 1'b0, 4'h3, 1'b0, 1'b0},
        {1'b1, 8'h02, 1'b0, 4'h3, 1'b0, 1'b0}
    };

    task automatic check(input string req, input logic [3:0] ev, input logic ec, input logic eu);
        n_cmp++;
        if (stored_val !== ev || chg_flag !== ec || unstable_flag !== eu) begin
            n_bad++;
            $display("FAIL %s: val/chg/unst actual %h/%b/%b expected %h/%b/%b",
                     req, stored_val, chg_flag, unstable_flag, ev, ec, eu);
        end
    endtask

    // one cycle of stimulus, returns at the following negedge
    task automatic cyc(input logic v, input logic [7:0] b, input logic clr);
        ma_valid   = v;
        ma_byte    = b;
        clr_status = clr;
        @(negedge clk);
        ma_valid   = 1'b0;
        clr_status = 1'b0;
    endtask

    task automatic send_mf(input logic [3:0] w, input logic clr_last);
        for (int p = 0; p < 4; p++) begin
            cyc(1'b1, {5'b11010, 2'(p), w[3-p]}, (p == 3) ? clr_last : 1'b0);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R10 in reset", 4'h0, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 after reset", 4'h0, 1'b0, 1'b0);

        // table walk: R1 R2 R6 R7 R8 R11 in integrated mode
        for (int i = 0; i < 27; i++) begin
            cyc(VEC[i][15], VEC[i][14:7], VEC[i][6]);
            check($sformatf("R2/R6/R11 vector %0d", i), VEC[i][5:2], VEC[i][1], VEC[i][0]);
        end

        // R9: switch to extracted with a phase-00 strobe that must be dropped
        mode_ext = 1'b1;
        cyc(1'b1, 8'hD1, 1'b0);
        check("R9 flush on mode change", 4'h0, 1'b0, 1'b0);
        cyc(1'b1, 8'hD2, 1'b0);   // tail of a word that never started
        cyc(1'b1, 8'hD5, 1'b0);
        cyc(1'b1, 8'hD7, 1'b0);
        for (int k = 0; k < 4; k++) send_mf(4'hB, 1'b0);
        check("R9/R5 not yet accepted after 4 words", 4'h0, 1'b0, 1'b0);
        send_mf(4'hB, 1'b0);
        check("R3/R5 word 1011 accepted", 4'hB, 1'b1, 1'b0);
        cyc(1'b0, 8'h00, 1'b1);
        check("R8 clear keeps value", 4'hB, 1'b0, 1'b0);

        // R4: restart on an early phase 00
        for (int k = 0; k < 4; k++) send_mf(4'h6, 1'b0);
        check("R5 run of 4 of 0110", 4'hB, 1'b0, 1'b0);
        cyc(1'b1, 8'hD1, 1'b0);
        cyc(1'b1, 8'hD2, 1'b0);
        cyc(1'b1, 8'hD4, 1'b0);
        cyc(1'b1, 8'hD0, 1'b0);   // phase 00 again: restart
        cyc(1'b1, 8'hD3, 1'b0);
        cyc(1'b1, 8'hD5, 1'b0);
        cyc(1'b1, 8'hD6, 1'b0);
        check("R4 restart word completes", 4'h6, 1'b1, 1'b0);
        cyc(1'b0, 8'h00, 1'b1);
        check("R8 clear", 4'h6, 1'b0, 1'b0);

        // R4: bad phase hunts for next 00
        for (int k = 0; k < 4; k++) send_mf(4'h9, 1'b0);
        cyc(1'b1, 8'hD0, 1'b0);
        cyc(1'b1, 8'hD3, 1'b0);
        cyc(1'b1, 8'hD7, 1'b0);   // phase 11 out of order
        cyc(1'b1, 8'hD5, 1'b0);   // ignored while hunting
        cyc(1'b1, 8'hD6, 1'b0);   // ignored while hunting
        check("R4 broken multiframe yields no word", 4'h6, 1'b0, 1'b0);
        send_mf(4'h9, 1'b0);
        check("R4/R5 run survives broken multiframe", 4'h9, 1'b1, 1'b0);

        // R7: unstable threshold
        for (int k = 0; k < 7; k++) send_mf((k % 2 == 0) ? 4'h1 : 4'h2, 1'b0);
        check("R7 seven quiet words", 4'h9, 1'b1, 1'b0);
        send_mf(4'h2, 1'b0);
        check("R7 eighth quiet word", 4'h9, 1'b1, 1'b1);
        cyc(1'b0, 8'h00, 1'b1);
        check("R8 clear both flags", 4'h9, 1'b0, 1'b0);

        // R6: write wins over a simultaneous clear
        for (int k = 0; k < 4; k++) send_mf(4'h4, 1'b0);
        send_mf(4'h4, 1'b1);
        check("R6 set wins over clear", 4'h4, 1'b1, 1'b0);

        // R9: back to integrated
        mode_ext = 1'b0;
        cyc(1'b0, 8'h00, 1'b0);
        check("R9 flush back to integrated", 4'h0, 1'b0, 1'b0);
        for (int k = 0; k < 5; k++) cyc(1'b1, 8'hF6, 1'b0);
        check("R1/R2 field from low bits", 4'h6, 1'b1, 1'b0);

        done = 1'b1;
        finish_run();
    end
endmodule